// File: doc/BRIEF.md
# Software Standby Wake-Up Controller

This block decides when a small processor system may stop its oscillator and how it comes back. A sleep request from the CPU, taken while the standby-select control bit is set, puts the system in software standby. In that state the oscillator and the system clock are gated off. The serial interface and the two PWM units are held in reset. Every other peripheral keeps its state.

Several wake sources are watched:
- a nonmaskable interrupt pin, with a selectable active edge;
- sixteen maskable interrupt lines, each with its own enable bit;
- ten key-input lines and eight wake-up-event lines, each with an input enable;
- an active-low reset pin;
- an active-low hardware-standby pin.

An interrupt wake restarts the oscillator but keeps the system clock off for a programmed settling time. It then turns the clock on and pulses an interrupt-handling request. A reset wake turns both the oscillator and the clock on at once and waits for the reset pin to rise before it pulses a reset-handling request. The hardware-standby pin overrides everything else.

The whole controller runs on one slow, always-running reference clock, which also times the settling delay. All pins are plain asynchronous control levels and are resynchronised inside the block. There is no data stream and no handshake.

Top module: `stby_wake_ctrl`

## Requirements
- R1: After `rst_n` is released, the block is in the running state: `osc_en`=1, `sys_clk_en`=1, `hw_stby`=0, `periph_rst`=000, `wake_irq`=0 and `wake_rst`=0.
- R2: A one-cycle `sleep_req` with `sby_sel`=1 gates both `osc_en` and `sys_clk_en` to 0 on the next clock edge. With `sby_sel`=0 the request is ignored and both stay 1.
- R3: `periph_rst` is 3'b111 (bit0 serial, bit1 and bit2 the PWM units) while in software standby or settling, and 3'b000 while running.
- R4: `nmi_rise_sel`=0 makes only a falling edge of `nmi_pin` wake the block; `nmi_rise_sel`=1 makes only a rising edge wake it. The opposite edge leaves the block in standby.
- R5: A high level on `irq_pin[i]` wakes the block only when `irq_en[i]`=1 and `cpu_mask`=0.
- R6: A high level on `key_pin[i]` or `wue_pin[i]` wakes the block only when the matching `key_en`/`wue_en` bit is 1 and `cpu_mask`=0.
- R7: After an interrupt wake, `osc_en`=1 with `sys_clk_en`=0 holds for exactly 8<<`settle_sel` cycles (000→8 up to 111→1024). Then `sys_clk_en` rises and `wake_irq` is high for exactly that first cycle.
- R8: `res_pin_n` low during standby or settling turns on `osc_en` and `sys_clk_en` without `wake_irq`. When the pin returns high, `wake_rst` pulses for one cycle.
- R9: `hstby_pin_n` low, from any state, gives `hw_stby`=1 with both clocks off, even when `res_pin_n` is low. On its release the block takes the reset path: clocks on, then a `wake_rst` pulse once `res_pin_n` is high.
- R10: Every pin passes two synchronising flops. A pin change made before clock edge k is acted on at edge k+2, so outputs move after the third edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running reference clock |
| rst_n | input | 1 | Active-low controller reset |
| sleep_req | input | 1 | One-cycle sleep instruction strobe from the CPU |
| sby_sel | input | 1 | 1: a sleep request enters software standby |
| settle_sel | input | 3 | Settling-time code, 8<<code cycles |
| nmi_pin | input | 1 | Nonmaskable interrupt pin |
| nmi_rise_sel | input | 1 | 0 falling, 1 rising edge for nmi_pin |
| irq_pin | input | 16 | Maskable interrupt lines, active high |
| irq_en | input | 16 | Per-line interrupt enables |
| key_pin | input | 10 | Key-input lines, active high |
| key_en | input | 10 | Key-input enables |
| wue_pin | input | 8 | Wake-up-event lines, active high |
| wue_en | input | 8 | Wake-up-event enables |
| cpu_mask | input | 1 | 1: CPU blocks maskable wake sources |
| res_pin_n | input | 1 | Active-low reset pin |
| hstby_pin_n | input | 1 | Active-low hardware-standby pin |
| osc_en | output | 1 | Oscillator enable |
| sys_clk_en | output | 1 | System clock gate enable |
| hw_stby | output | 1 | Hardware-standby state indicator |
| periph_rst | output | 3 | Reset to serial interface and both PWM units |
| wake_irq | output | 1 | One-cycle interrupt-handling request |
| wake_rst | output | 1 | One-cycle reset-handling request |

## Verification
Four output combinations expose the internal state directly: clocks off, oscillator only, both on, and hardware standby. A wrong state therefore appears at the ports on the edge after it is entered.

A fault in the settling counter can only show as a wrong length of the oscillator-only window, so that window is timed cycle by cycle for several codes, including the longest one. A fault in qualification appears either as a standby that never ends or as a wake that should not happen, within three edges of the line change.

// File: rtl/stby_pkg.sv
package stby_pkg;
  typedef enum logic [2:0] {
    ST_RUN      = 3'd0,
    ST_SW_STBY  = 3'd1,
    ST_SETTLE   = 3'd2,
    ST_HW_STBY  = 3'd3,
    ST_RST_WAIT = 3'd4
  } stby_state_e;

  localparam int PERIPH_N = 3;
endpackage

// File: rtl/stby_sync.sv
module stby_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/stby_wake_qual.sv
module stby_wake_qual #(
  parameter int NUM_IRQ = 16,
  parameter int NUM_KEY = 10,
  parameter int NUM_WUE = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               nmi_s,
  input  logic               nmi_rise_sel,
  input  logic [NUM_IRQ-1:0] irq_s,
  input  logic [NUM_IRQ-1:0] irq_en,
  input  logic [NUM_KEY-1:0] key_s,
  input  logic [NUM_KEY-1:0] key_en,
  input  logic [NUM_WUE-1:0] wue_s,
  input  logic [NUM_WUE-1:0] wue_en,
  input  logic               cpu_mask,
  output logic               wake
);
  logic nmi_prev;
  logic nmi_edge;
  logic maskable_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) nmi_prev <= 1'b0;
    else        nmi_prev <= nmi_s;
  end

  // edge polarity chosen by nmi_rise_sel
  assign nmi_edge = nmi_rise_sel ? (nmi_s & ~nmi_prev) : (~nmi_s & nmi_prev);

  assign maskable_req = (|(irq_s & irq_en)) | (|(key_s & key_en)) | (|(wue_s & wue_en));

  assign wake = nmi_edge | (maskable_req & ~cpu_mask);
endmodule

// File: rtl/stby_settle_cnt.sv
module stby_settle_cnt #(
  parameter int SEL_W = 3,
  parameter int BASE_SHIFT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             done
);
  localparam int CNT_W = BASE_SHIFT + (1 << SEL_W) - 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   span;
  logic [CNT_W-1:0] ld_val;

  // span = 2^(BASE_SHIFT+sel); counter counts span-1 down to 0
  assign span   = {{CNT_W{1'b0}}, 1'b1} << (BASE_SHIFT + int'(sel));
  assign ld_val = CNT_W'(span - {{CNT_W{1'b0}}, 1'b1});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (load)               cnt <= ld_val;
    else if (run && cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/stby_wake_ctrl.sv
module stby_wake_ctrl
  import stby_pkg::*;
#(
  parameter int NUM_IRQ = 16,
  parameter int NUM_KEY = 10,
  parameter int NUM_WUE = 8,
  parameter int SEL_W = 3,
  parameter int BASE_SHIFT = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sleep_req,
  input  logic               sby_sel,
  input  logic [SEL_W-1:0]   settle_sel,
  input  logic               nmi_pin,
  input  logic               nmi_rise_sel,
  input  logic [NUM_IRQ-1:0] irq_pin,
  input  logic [NUM_IRQ-1:0] irq_en,
  input  logic [NUM_KEY-1:0] key_pin,
  input  logic [NUM_KEY-1:0] key_en,
  input  logic [NUM_WUE-1:0] wue_pin,
  input  logic [NUM_WUE-1:0] wue_en,
  input  logic               cpu_mask,
  input  logic               res_pin_n,
  input  logic               hstby_pin_n,
  output logic               osc_en,
  output logic               sys_clk_en,
  output logic               hw_stby,
  output logic [PERIPH_N-1:0] periph_rst,
  output logic               wake_irq,
  output logic               wake_rst
);
  localparam int SYN_W = NUM_IRQ + NUM_KEY + NUM_WUE + 3;
  localparam logic [SYN_W-1:0] SYN_RST = {2'b11, {(SYN_W-2){1'b0}}};

  logic [SYN_W-1:0]   syn_q;
  logic [NUM_IRQ-1:0] irq_s;
  logic [NUM_KEY-1:0] key_s;
  logic [NUM_WUE-1:0] wue_s;
  logic nmi_s, res_s, hstby_s;
  logic wake, settle_done, settle_load;
  logic go_irq, go_rst;
  stby_state_e state, state_nx;

  stby_sync #(.W(SYN_W), .STAGES(SYNC_STAGES), .RST_VAL(SYN_RST)) i_sync (
    .clk(clk), .rst_n(rst_n),
    .d({hstby_pin_n, res_pin_n, nmi_pin, wue_pin, key_pin, irq_pin}),
    .q(syn_q)
  );

  assign irq_s   = syn_q[NUM_IRQ-1:0];
  assign key_s   = syn_q[NUM_IRQ +: NUM_KEY];
  assign wue_s   = syn_q[NUM_IRQ+NUM_KEY +: NUM_WUE];
  assign nmi_s   = syn_q[SYN_W-3];
  assign res_s   = syn_q[SYN_W-2];
  assign hstby_s = syn_q[SYN_W-1];

  stby_wake_qual #(.NUM_IRQ(NUM_IRQ), .NUM_KEY(NUM_KEY), .NUM_WUE(NUM_WUE)) i_qual (
    .clk(clk), .rst_n(rst_n),
    .nmi_s(nmi_s), .nmi_rise_sel(nmi_rise_sel),
    .irq_s(irq_s), .irq_en(irq_en),
    .key_s(key_s), .key_en(key_en),
    .wue_s(wue_s), .wue_en(wue_en),
    .cpu_mask(cpu_mask), .wake(wake)
  );

  stby_settle_cnt #(.SEL_W(SEL_W), .BASE_SHIFT(BASE_SHIFT)) i_cnt (
    .clk(clk), .rst_n(rst_n),
    .load(settle_load), .run(state == ST_SETTLE),
    .sel(settle_sel), .done(settle_done)
  );

  // priority: hardware standby, then reset pin, then interrupts
  always_comb begin
    state_nx    = state;
    settle_load = 1'b0;
    go_irq      = 1'b0;
    go_rst      = 1'b0;
    if (!hstby_s) begin
      state_nx = ST_HW_STBY;
    end else begin
      unique case (state)
        ST_HW_STBY: state_nx = ST_RST_WAIT;
        ST_RST_WAIT: begin
          if (res_s) begin
            state_nx = ST_RUN;
            go_rst   = 1'b1;
          end
        end
        ST_RUN: begin
          if (!res_s)                  state_nx = ST_RST_WAIT;
          else if (sleep_req && sby_sel) state_nx = ST_SW_STBY;
        end
        ST_SW_STBY: begin
          if (!res_s) begin
            state_nx = ST_RST_WAIT;
          end else if (wake) begin
            state_nx    = ST_SETTLE;
            settle_load = 1'b1;
          end
        end
        ST_SETTLE: begin
          if (!res_s) begin
            state_nx = ST_RST_WAIT;
          end else if (settle_done) begin
            state_nx = ST_RUN;
            go_irq   = 1'b1;
          end
        end
        default: state_nx = ST_RST_WAIT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_RUN;
      wake_irq <= 1'b0;
      wake_rst <= 1'b0;
    end else begin
      state    <= state_nx;
      wake_irq <= go_irq;
      wake_rst <= go_rst;
    end
  end

  assign osc_en     = (state == ST_RUN) || (state == ST_SETTLE) || (state == ST_RST_WAIT);
  assign sys_clk_en = (state == ST_RUN) || (state == ST_RST_WAIT);
  assign hw_stby    = (state == ST_HW_STBY);

  for (genvar g = 0; g < PERIPH_N; g++) begin : g_prst
    assign periph_rst[g] = (state == ST_SW_STBY) || (state == ST_SETTLE);
  end
endmodule

// File: rtl/stby_wake_chk.sv
module stby_wake_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       osc_en,
  input logic       sys_clk_en,
  input logic       hw_stby,
  input logic [2:0] periph_rst,
  input logic       wake_irq,
  input logic       wake_rst
);
  // R2: the system clock never runs without the oscillator
  a_r2_clk_needs_osc: assert property (@(posedge clk) disable iff (!rst_n)
    sys_clk_en |-> osc_en);

  // R3: clock gated outside hardware standby means the three peripherals are in reset
  a_r3_prst_in_standby: assert property (@(posedge clk) disable iff (!rst_n)
    (!sys_clk_en && !hw_stby) |-> (periph_rst == 3'b111));

  // R3: running clock means no peripheral reset
  a_r3_prst_clear_run: assert property (@(posedge clk) disable iff (!rst_n)
    sys_clk_en |-> (periph_rst == 3'b000));

  // R7: interrupt request is a single cycle
  a_r7_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    wake_irq |=> !wake_irq);

  // R7: interrupt request arrives right as the clock is turned back on after settling
  a_r7_irq_after_settle: assert property (@(posedge clk) disable iff (!rst_n)
    wake_irq |-> (sys_clk_en && $past(osc_en) && !$past(sys_clk_en)));

  // R8: reset request is a single cycle
  a_r8_rst_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    wake_rst |=> !wake_rst);

  // R9: hardware standby keeps both clocks off
  a_r9_hw_clocks_off: assert property (@(posedge clk) disable iff (!rst_n)
    hw_stby |-> (!osc_en && !sys_clk_en));

  // R9: hardware standby is never left straight into running with an interrupt request
  a_r9_hw_exit_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hw_stby) |-> !wake_irq);
endmodule

bind stby_wake_ctrl stby_wake_chk i_stby_wake_chk (
  .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .sys_clk_en(sys_clk_en),
  .hw_stby(hw_stby), .periph_rst(periph_rst),
  .wake_irq(wake_irq), .wake_rst(wake_rst)
);

// File: tb/test_stby_wake_ctrl.sv
module test_stby_wake_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n, sleep_req, sby_sel, nmi_pin, nmi_rise_sel, cpu_mask, res_pin_n, hstby_pin_n;
  logic [2:0]  settle_sel;
  logic [15:0] irq_pin, irq_en;
  logic [9:0]  key_pin, key_en;
  logic [7:0]  wue_pin, wue_en;
  logic osc_en, sys_clk_en, hw_stby, wake_irq, wake_rst;
  logic [2:0] periph_rst;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stby_wake_ctrl i_stby_wake_ctrl (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .sby_sel(sby_sel),
    .settle_sel(settle_sel), .nmi_pin(nmi_pin), .nmi_rise_sel(nmi_rise_sel),
    .irq_pin(irq_pin), .irq_en(irq_en), .key_pin(key_pin), .key_en(key_en),
    .wue_pin(wue_pin), .wue_en(wue_en), .cpu_mask(cpu_mask),
    .res_pin_n(res_pin_n), .hstby_pin_n(hstby_pin_n),
    .osc_en(osc_en), .sys_clk_en(sys_clk_en), .hw_stby(hw_stby),
    .periph_rst(periph_rst), .wake_irq(wake_irq), .wake_rst(wake_rst)
  );

  // kind: 0 irq, 1 key, 2 wue
  typedef struct packed {
    logic [1:0] kind;
    logic [3:0] idx;
    logic       en;
    logic       mask;
    logic [2:0] sel;
    logic       exp_wake;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 4'd3,  1'b1, 1'b0, 3'd0, 1'b1},
    '{2'd0, 4'd15, 1'b0, 1'b0, 3'd1, 1'b0},
    '{2'd0, 4'd7,  1'b1, 1'b1, 3'd2, 1'b0},
    '{2'd0, 4'd0,  1'b1, 1'b0, 3'd2, 1'b1},
    '{2'd1, 4'd9,  1'b1, 1'b0, 3'd1, 1'b1},
    '{2'd1, 4'd4,  1'b0, 1'b0, 3'd0, 1'b0},
    '{2'd1, 4'd2,  1'b1, 1'b1, 3'd0, 1'b0},
    '{2'd2, 4'd7,  1'b1, 1'b0, 3'd3, 1'b1},
    '{2'd2, 4'd0,  1'b0, 1'b0, 3'd0, 1'b0},
    '{2'd2, 4'd5,  1'b1, 1'b1, 3'd0, 1'b0},
    '{2'd0, 4'd8,  1'b1, 1'b0, 3'd7, 1'b1},
    '{2'd1, 4'd0,  1'b1, 1'b0, 3'd5, 1'b1}
  };

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_line(input logic [1:0] kind, input int idx, input logic v);
    case (kind)
      2'd0: irq_pin[idx] = v;
      2'd1: key_pin[idx] = v;
      default: wue_pin[idx] = v;
    endcase
  endtask

  task automatic set_en(input logic [1:0] kind, input int idx, input logic v);
    irq_en = '0; key_en = '0; wue_en = '0;
    case (kind)
      2'd0: irq_en[idx] = v;
      2'd1: key_en[idx] = v;
      default: wue_en[idx] = v;
    endcase
  endtask

  // R2: sleep with standby selected gates the clocks on the next edge
  task automatic enter_standby();
    sby_sel = 1'b1; sleep_req = 1'b1;
    tick(1);
    sleep_req = 1'b0;
    chk(osc_en == 1'b0 && sys_clk_en == 1'b0, "R2 standby entry", {osc_en, sys_clk_en}, 0);
  endtask

  // R7: count oscillator-only cycles until the clock comes back
  task automatic settle_check(input int start, input int exp_n, input string req);
    int cnt = start;
    int guard = 0;
    while (!sys_clk_en && guard < 3000) begin
      tick(1);
      guard++;
      if (osc_en && !sys_clk_en) cnt++;
    end
    chk(cnt == exp_n, req, cnt, exp_n);
    chk(wake_irq == 1'b1, {req, " irq pulse"}, wake_irq, 1);
    tick(1);
    chk(wake_irq == 1'b0, {req, " irq pulse width"}, wake_irq, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sleep_req = 1'b0; sby_sel = 1'b0; settle_sel = 3'd0;
    nmi_pin = 1'b0; nmi_rise_sel = 1'b1; cpu_mask = 1'b0;
    res_pin_n = 1'b1; hstby_pin_n = 1'b1;
    irq_pin = '0; irq_en = '0; key_pin = '0; key_en = '0; wue_pin = '0; wue_en = '0;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    chk(osc_en && sys_clk_en && !hw_stby, "R1 clocks after reset", {osc_en, sys_clk_en, hw_stby}, 6);
    chk(periph_rst == 3'b000 && !wake_irq && !wake_rst, "R1 idle outputs",
        {periph_rst, wake_irq, wake_rst}, 0);

    // R2 sleep ignored when standby not selected
    sby_sel = 1'b0; sleep_req = 1'b1;
    tick(1);
    sleep_req = 1'b0;
    tick(2);
    chk(osc_en && sys_clk_en, "R2 sleep without select", {osc_en, sys_clk_en}, 3);

    // Table walk: R5 / R6 / R7
    for (int v = 0; v < NV; v++) begin
      settle_sel = VEC[v].sel;
      cpu_mask   = VEC[v].mask;
      set_en(VEC[v].kind, int'(VEC[v].idx), VEC[v].en);
      enter_standby();
      chk(periph_rst == 3'b111, "R3 peripherals reset in standby", periph_rst, 7);
      set_line(VEC[v].kind, int'(VEC[v].idx), 1'b1);
      if (VEC[v].exp_wake) begin
        settle_check(0, 8 << VEC[v].sel,
                     VEC[v].kind == 2'd0 ? "R5 irq wake settle" : "R6 key/wue wake settle");
        chk(periph_rst == 3'b000, "R3 peripherals released", periph_rst, 0);
      end else begin
        tick(6);
        chk(osc_en == 1'b0, VEC[v].kind == 2'd0 ? "R5 blocked irq" : "R6 blocked key/wue",
            osc_en, 0);
        set_line(VEC[v].kind, int'(VEC[v].idx), 1'b0);
        nmi_pin = 1'b1;     // rising edge recovery, R4 with nmi_rise_sel=1
        settle_check(0, 8 << VEC[v].sel, "R4 nmi rising wake");
        nmi_pin = 1'b0;
      end
      set_line(VEC[v].kind, int'(VEC[v].idx), 1'b0);
      irq_en = '0; key_en = '0; wue_en = '0; cpu_mask = 1'b0;
      tick(4);
    end

    // R4 falling edge selected: rising ignored, falling wakes; R10 latency
    nmi_rise_sel = 1'b0; settle_sel = 3'd1;
    enter_standby();
    nmi_pin = 1'b1;
    tick(6);
    chk(osc_en == 1'b0, "R4 opposite edge ignored", osc_en, 0);
    nmi_pin = 1'b0;
    tick(2);
    chk(osc_en == 1'b0, "R10 two-flop latency", osc_en, 0);
    tick(1);
    chk(osc_en == 1'b1, "R10 wake on third edge", osc_en, 1);
    settle_check(1, 16, "R7 settle after nmi falling");
    nmi_rise_sel = 1'b1;
    tick(3);

    // R8 reset pin during standby
    enter_standby();
    res_pin_n = 1'b0;
    tick(3);
    chk(osc_en && sys_clk_en, "R8 clocks on at reset", {osc_en, sys_clk_en}, 3);
    tick(5);
    chk(!wake_irq && !wake_rst, "R8 no request while held", {wake_irq, wake_rst}, 0);
    res_pin_n = 1'b1;
    begin
      int seen = 0;
      for (int i = 0; i < 6; i++) begin
        tick(1);
        if (wake_rst) seen++;
      end
      chk(seen == 1, "R8 single reset request", seen, 1);
    end

    // R9 hardware standby overrides reset, exits via reset path
    enter_standby();
    res_pin_n = 1'b0;
    hstby_pin_n = 1'b0;
    tick(4);
    chk(hw_stby && !osc_en && !sys_clk_en, "R9 hardware standby", {hw_stby, osc_en, sys_clk_en}, 4);
    res_pin_n = 1'b1;
    tick(4);
    chk(hw_stby == 1'b1, "R9 held while pin low", hw_stby, 1);
    hstby_pin_n = 1'b0;
    begin
      int seen = 0;
      hstby_pin_n = 1'b1;
      for (int i = 0; i < 8; i++) begin
        tick(1);
        if (wake_rst) seen++;
      end
      chk(seen == 1 && !hw_stby && sys_clk_en, "R9 exit through reset", seen, 1);
    end

    // R9 from running state
    hstby_pin_n = 1'b0;
    tick(3);
    chk(hw_stby == 1'b1, "R9 from run", hw_stby, 1);
    hstby_pin_n = 1'b1;
    tick(6);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule